// File: doc/BRIEF.md
# Dual-Clock Mailbox Register With Flag

This block passes a single data word from a writer clocked by one clock to a reader clocked by an unrelated clock. A write that targets the mailbox captures the word and drives an active-low flag in the writer's domain low. While the flag is low, further mailbox writes are dropped, so a word that has not been read cannot be overwritten. When the reader takes the word, the read event crosses back into the writer's domain, and the flag returns high.

Write and read events cross the domains as toggles through two-stage synchronizers. The read side has one select line. It steers either the mailbox word or the word from the neighbouring FIFO's output register onto the read bus. The same select line also marks a read as a mailbox read. A master reset or a partial reset of the associated FIFO empties the mailbox and raises the flag.

Top module: `dual_clk_mailbox`

## Requirements
- R1: A write clock rising edge with wr_en_i=1, wr_mbx_sel_i=1 and mbx_full_no=1 captures wr_data_i into the mailbox. The same edge drives mbx_full_no to 0.
- R2: While mbx_full_no=0, a mailbox write leaves the stored word unchanged and keeps mbx_full_no at 0. A back-to-back write cannot overwrite an unread word.
- R3: Once a written word has had two read clock edges to reach the read side, a read clock edge with rd_en_i=1 and rd_mbx_sel_i=1 accepts the read. mbx_full_no then stays 0 after the first write clock edge that follows and is 1 after the second.
- R4: rd_data_o equals the mailbox word when rd_oe_i=1 and rd_mbx_sel_i=1. It equals fifo_data_i when rd_oe_i=1 and rd_mbx_sel_i=0. It is all zeros when rd_oe_i=0.
- R5: A read with rd_mbx_sel_i=0 does not release the mailbox: mbx_full_no stays 0. A mailbox read while the mailbox is empty has no effect: a later write still drives the flag low, and it stays low.
- R6: A write with wr_mbx_sel_i=0 changes neither the stored word nor mbx_full_no.
- R7: While rst_ni=0, mbx_full_no is 1 and the stored mailbox word is zero.
- R8: While part_rst_ni=0, mbx_full_no is 1 and the stored word is zero. After release, a write is accepted as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Writer clock |
| rclk_i | input | 1 | Reader clock |
| rst_ni | input | 1 | Master reset, active low, asynchronous |
| part_rst_ni | input | 1 | Partial reset of the associated FIFO, active low, asynchronous |
| wr_en_i | input | 1 | Write strobe, writer domain |
| wr_mbx_sel_i | input | 1 | Write targets the mailbox |
| wr_data_i | input | DATA_W | Word to write |
| mbx_full_no | output | 1 | Mailbox flag, low while a word is unread |
| rd_en_i | input | 1 | Read strobe, reader domain |
| rd_mbx_sel_i | input | 1 | Read targets the mailbox and steers the read bus |
| rd_oe_i | input | 1 | Read bus enable |
| fifo_data_i | input | DATA_W | FIFO output register word |
| rd_data_o | output | DATA_W | Read bus |

## Verification
A write shows on mbx_full_no at the write edge itself. The bench therefore samples at the next falling write clock edge. The read side needs two read clock edges before a mailbox read is accepted, so the bench lets three pass. After an accepted read, the flag is sampled one nanosecond after each of the next two write clock edges: it must still be low after the first and high after the second. The read bus is combinational and is sampled one nanosecond after its controls change. The reset checks are taken while the reset is held.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_SYNC_STAGES = 2;
  typedef enum logic [1:0] {SRC_NONE, SRC_FIFO, SRC_MBX} rd_src_e;
endpackage

// File: rtl/mbx_tgl_sync.sv
module mbx_tgl_sync #(
  parameter int unsigned STAGES = mbx_pkg::MBX_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic tgl_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= tgl_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], tgl_i};
      end
    end
  endgenerate

  assign tgl_o = sync_q[STAGES-1];
endmodule

// File: rtl/mbx_wr_side.sv
module mbx_wr_side #(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ack_tgl_i,
  output logic              req_tgl_o,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  logic              req_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_fire;

  // full while a sent toggle is not yet echoed back
  assign full_o  = req_q ^ ack_tgl_i;
  assign wr_fire = wr_en_i & wr_sel_i & ~full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      data_q <= '0;
    end else if (wr_fire) begin
      req_q  <= ~req_q;
      data_q <= wr_data_i;
    end
  end

  assign req_tgl_o = req_q;
  assign data_o    = data_q;

  // R1
  wr_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i && !full_o) |=> (full_o && data_o == $past(wr_data_i)));

  // R2
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i && full_o) |=> (full_o && $stable(data_o)));

  // R6
  sel_low_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i && !full_o) |=> (!full_o && $stable(data_o)));
endmodule

// File: rtl/mbx_rd_side.sv
module mbx_rd_side (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_en_i,
  input  logic rd_sel_i,
  input  logic req_tgl_i,
  output logic ack_tgl_o
);
  logic ack_q;
  logic avail;
  logic rd_fire;

  assign avail   = req_tgl_i ^ ack_q;
  assign rd_fire = rd_en_i & rd_sel_i & avail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ack_q <= 1'b0;
    else if (rd_fire) ack_q <= ~ack_q;
  end

  assign ack_tgl_o = ack_q;

  // R3
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel_i && avail) |=> !avail);

  // R5
  empty_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !avail) |=> $stable(ack_tgl_o));
endmodule

// File: rtl/dual_clk_mailbox.sv
module dual_clk_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SYNC_STAGES = MBX_SYNC_STAGES
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              part_rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_mbx_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              mbx_full_no,
  input  logic              rd_en_i,
  input  logic              rd_mbx_sel_i,
  input  logic              rd_oe_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              rst_n;
  logic              req_tgl, req_tgl_rd;
  logic              ack_tgl, ack_tgl_wr;
  logic [DATA_W-1:0] mbx_data;
  logic              full;
  rd_src_e           rd_src;

  // either reset empties the mailbox
  assign rst_n = rst_ni & part_rst_ni;

  mbx_wr_side #(.DATA_W(DATA_W)) u_wr (
    .clk_i     (wclk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_mbx_sel_i),
    .wr_data_i (wr_data_i),
    .ack_tgl_i (ack_tgl_wr),
    .req_tgl_o (req_tgl),
    .data_o    (mbx_data),
    .full_o    (full)
  );

  mbx_tgl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i  (rclk_i),
    .rst_ni (rst_n),
    .tgl_i  (req_tgl),
    .tgl_o  (req_tgl_rd)
  );

  mbx_rd_side u_rd (
    .clk_i     (rclk_i),
    .rst_ni    (rst_n),
    .rd_en_i   (rd_en_i),
    .rd_sel_i  (rd_mbx_sel_i),
    .req_tgl_i (req_tgl_rd),
    .ack_tgl_o (ack_tgl)
  );

  mbx_tgl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i  (wclk_i),
    .rst_ni (rst_n),
    .tgl_i  (ack_tgl),
    .tgl_o  (ack_tgl_wr)
  );

  assign mbx_full_no = ~full;

  always_comb begin
    if (!rd_oe_i)          rd_src = SRC_NONE;
    else if (rd_mbx_sel_i) rd_src = SRC_MBX;
    else                   rd_src = SRC_FIFO;
  end

  always_comb begin
    unique case (rd_src)
      SRC_MBX:  rd_data_o = mbx_data;
      SRC_FIFO: rd_data_o = fifo_data_i;
      default:  rd_data_o = '0;
    endcase
  end

  // R7 R8
  rst_flag_chk: assert property (@(posedge wclk_i)
    !rst_n |-> (mbx_full_no && mbx_data == '0));

  // R2
  hold_word_chk: assert property (@(posedge wclk_i) disable iff (!rst_n)
    (!mbx_full_no && $past(!mbx_full_no)) |-> $stable(mbx_data));
endmodule

// File: tb/dual_clk_mailbox_tb.sv
`timescale 1ns/1ps
module dual_clk_mailbox_tb;
  localparam int unsigned W = 36;

  logic         wclk_i = 1'b0, rclk_i = 1'b0;
  logic         rst_ni = 1'b0, part_rst_ni = 1'b1;
  logic         wr_en_i = 1'b0, wr_mbx_sel_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic         mbx_full_no;
  logic         rd_en_i = 1'b0, rd_mbx_sel_i = 1'b0, rd_oe_i = 1'b0;
  logic [W-1:0] fifo_data_i = '0;
  logic [W-1:0] rd_data_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 wclk_i = ~wclk_i;
  initial begin
    #1;
    forever #2 rclk_i = ~rclk_i;
  end

  dual_clk_mailbox #(.DATA_W(W)) u_dut (
    .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .part_rst_ni(part_rst_ni),
    .wr_en_i(wr_en_i), .wr_mbx_sel_i(wr_mbx_sel_i), .wr_data_i(wr_data_i),
    .mbx_full_no(mbx_full_no), .rd_en_i(rd_en_i), .rd_mbx_sel_i(rd_mbx_sel_i),
    .rd_oe_i(rd_oe_i), .fifo_data_i(fifo_data_i), .rd_data_o(rd_data_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_op(input logic sel, input logic [W-1:0] d);
    @(negedge wclk_i);
    wr_en_i = 1'b1; wr_mbx_sel_i = sel; wr_data_i = d;
    @(negedge wclk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_op(input logic sel);
    @(negedge rclk_i);
    rd_en_i = 1'b1; rd_mbx_sel_i = sel;
    @(negedge rclk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic peek_mbx(input string req, input logic [W-1:0] exp);
    rd_oe_i = 1'b1; rd_mbx_sel_i = 1'b1;
    #1 check(req, rd_data_o, exp);
  endtask

  task automatic wait_wclk(input int n);
    for (int k = 0; k < n; k++) @(posedge wclk_i);
    #1;
  endtask

  initial begin
    logic [W-1:0] d;
    // R7: held in master reset
    repeat (3) @(posedge wclk_i);
    #1 check("R7 flag", W'(mbx_full_no), W'(1));
    peek_mbx("R7 data", '0);
    @(negedge wclk_i) rst_ni = 1'b1;

    // R4: read bus steering
    fifo_data_i = 36'hA_5C3C_9E17;
    rd_oe_i = 1'b1; rd_mbx_sel_i = 1'b0;
    #1 check("R4 fifo", rd_data_o, 36'hA_5C3C_9E17);
    rd_oe_i = 1'b0; rd_mbx_sel_i = 1'b1;
    #1 check("R4 off", rd_data_o, '0);

    // R5: read of empty mailbox, then write must still hold the flag low
    rd_op(1'b1);
    wait_wclk(4);
    check("R5 empty rd flag", W'(mbx_full_no), W'(1));
    wr_op(1'b1, 36'h1_1111_1111);
    wait_wclk(6);
    check("R5 empty rd then wr", W'(mbx_full_no), W'(0));
    repeat (3) @(posedge rclk_i);
    rd_op(1'b1);
    wait_wclk(3);
    check("R5 drain", W'(mbx_full_no), W'(1));

    // sweep of data patterns through the full write/read cycle
    for (int i = 0; i < 16; i++) begin
      d = 36'h9_1234_5678 ^ (W'(i) * 36'h0_0F0F_1357);
      // R6: unselected write does nothing
      wr_op(1'b0, ~d);
      check("R6 flag", W'(mbx_full_no), W'(1));
      // R1
      wr_op(1'b1, d);
      check("R1 flag", W'(mbx_full_no), W'(0));
      peek_mbx("R1 data", d);
      // R2: back-to-back write dropped
      wr_op(1'b1, ~d);
      check("R2 flag", W'(mbx_full_no), W'(0));
      peek_mbx("R2 data", d);
      // R4 with live mailbox word
      fifo_data_i = ~d ^ W'(i);
      rd_mbx_sel_i = 1'b0;
      #1 check("R4 fifo sweep", rd_data_o, ~d ^ W'(i));
      // R5: unselected read does not release
      repeat (3) @(posedge rclk_i);
      rd_op(1'b0);
      wait_wclk(4);
      check("R5 sel low rd", W'(mbx_full_no), W'(0));
      // R3: release after two write clock edges
      rd_op(1'b1);
      wait_wclk(1);
      check("R3 flag edge1", W'(mbx_full_no), W'(0));
      wait_wclk(1);
      check("R3 flag edge2", W'(mbx_full_no), W'(1));
      // R6: unselected write after release keeps the word
      wr_op(1'b0, ~d);
      check("R6 idle flag", W'(mbx_full_no), W'(1));
      peek_mbx("R6 data", d);
    end

    // R8: partial reset clears a pending word
    wr_op(1'b1, 36'hC_0FFE_E123);
    @(negedge wclk_i) part_rst_ni = 1'b0;
    wait_wclk(2);
    check("R8 flag", W'(mbx_full_no), W'(1));
    peek_mbx("R8 data", '0);
    @(negedge wclk_i) part_rst_ni = 1'b1;
    wait_wclk(1);
    wr_op(1'b1, 36'h3_3333_3333);
    check("R8 wr after", W'(mbx_full_no), W'(0));
    peek_mbx("R8 data after", 36'h3_3333_3333);

    // R7: master reset mid-operation
    @(negedge wclk_i) rst_ni = 1'b0;
    wait_wclk(2);
    check("R7 mid flag", W'(mbx_full_no), W'(1));
    peek_mbx("R7 mid data", '0);
    @(negedge wclk_i) rst_ni = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule